// File: doc/BRIEF.md
# Per-Space Bus Wait-State Inserter

This block stretches external bus accesses by a number of wait states that depends on the address space being accessed. A 12-bit configuration register holds four 3-bit wait counts. One count is for I/O space, one for data space, and two are for program space: one for the upper half and one for the lower half, chosen by the most significant program address bit. When the core starts an access, the block loads the count for the selected space into a down-counter. It holds bus-ready low until that count has run out.

An external READY line can only lengthen an access, never shorten it. The programmed wait states are always inserted, whatever level READY has. Once the count has expired, the access ends in the first cycle in which READY is high. The configuration register is read and written through a simple register port. It answers only at I/O address 0xFFFC. It comes out of reset at the slowest setting, so the first accesses are safe against slow devices.

Top module: `waitgen_top`

## Requirements
- R1: With a loaded count of zero and READY high, bus_ready is high in the same cycle in which acc_start is sampled, so the access takes one cycle.
- R2: The register fields are I/O in bits 11:9, data in bits 8:6, upper program in bits 5:3 and lower program in bits 2:0. The space code is 0 for data, 1 for program and 2 for I/O. For program space, acc_addr_msb=1 selects the upper field. An access with count N and READY high ends N cycles after its start cycle.
- R3: Register bits 15:12 always read as zero, and writes to them are ignored.
- R4: After reset every field is 7, the register reads 0x0FFF, and bus_ready is low while no access is running.
- R5: READY low during the programmed wait cycles neither shortens nor lengthens the access. bus_ready never rises before the loaded count has expired.
- R6: If READY is still low after the count expires, the access is held until the first cycle with READY high. bus_ready is never high while READY is low.
- R7: The register is decoded only at address 0xFFFC. A write to any other address changes nothing, and a read at any other address returns zero.
- R8: The count is latched when an access starts. A register write made in the start cycle, or during the access, affects only later accesses.
- R9: An acc_start pulse while an access is in progress is ignored. It neither reloads the counter nor starts a second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | One-cycle strobe marking the first cycle of a bus access |
| acc_space | input | 2 | Space of the access: 0 data, 1 program, 2 I/O |
| acc_addr_msb | input | 1 | Program address bit 15, selects the upper or lower program field |
| ext_ready | input | 1 | External ready line; low adds wait states after the programmed count |
| bus_ready | output | 1 | High in the cycle in which the current access completes |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register port address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, zero when not selected |

## Verification
The bench first checks that each field lands in its own bit range and that the program-address bit picks the correct half. A design that swapped two fields, or inverted the half select, would give the wrong latency for a single space. It then drives READY low both inside and beyond the programmed window. A design that let READY end the wait early, or that added READY cycles on top of the count, would finish on the wrong cycle. Register writes are placed in the start cycle and in the middle of an access, and an extra start pulse is sent mid-access. A design that re-read the register, or restarted its counter, would change the in-flight latency or produce a second ready. Writes to reserved bits and to a neighbouring address are also covered. A design that stored those bits, or that decoded the address only partly, would read back the wrong value.

// File: rtl/ws_pkg.sv
// Package: shared constants for the wait-state inserter.
// Assumes a 3-bit wait field per space and four fields in the register.
package ws_pkg;
    localparam int WAIT_W     = 3;
    localparam int NUM_FIELDS = 4;

    // Space codes on acc_space
    localparam logic [1:0] SP_DATA = 2'd0;
    localparam logic [1:0] SP_PROG = 2'd1;
    localparam logic [1:0] SP_IO   = 2'd2;

    // Field slots in the register, slot k occupies bits k*WAIT_W +: WAIT_W
    localparam int FLD_PLO  = 0;
    localparam int FLD_PHI  = 1;
    localparam int FLD_DATA = 2;
    localparam int FLD_IO   = 3;
endpackage

// File: rtl/ws_cfg_reg.sv
// Module: configuration register holding the per-space wait counts.
// Decodes one address, resets all fields to all-ones, returns zero
// in the unused upper bits. Assumes DATA_W > NUM_FIELDS*WAIT_W.
module ws_cfg_reg #(
    parameter int          WAIT_W     = 3,
    parameter int          NUM_FIELDS = 4,
    parameter int          DATA_W     = 16,
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] CFG_ADDR   = 16'hFFFC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_FIELDS*WAIT_W-1:0]  fields
);
    localparam int CFG_W = NUM_FIELDS * WAIT_W;

    logic [CFG_W-1:0] cfg;
    logic             hit;
    logic             rsv_unused;

    // Address match for the single register
    assign hit = (addr == CFG_ADDR[ADDR_W-1:0]);

    // Reserved write bits are dropped
    assign rsv_unused = ^wdata[DATA_W-1:CFG_W];

    // Register update: slowest setting on reset, load on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '1;
        end else if (wr_en && hit) begin
            cfg <= wdata[CFG_W-1:0];
        end
    end

    // Read path: zero-extended register when selected, zero otherwise
    always_comb begin
        rdata = '0;
        if (rd_en && hit) begin
            rdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
        end
    end

    assign fields = cfg;

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (fields == $past(wdata[CFG_W-1:0])));

    assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CFG_W] == '0);

    assert_no_stray_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit) |=> $stable(fields));
endmodule

// File: rtl/ws_field_sel.sv
// Module: picks the wait count for the space of the current access.
// Program space uses the address MSB to choose the upper or lower field.
// Assumes an unused space code behaves like I/O.
module ws_field_sel #(
    parameter int WAIT_W     = 3,
    parameter int NUM_FIELDS = 4
) (
    input  logic [NUM_FIELDS*WAIT_W-1:0] fields,
    input  logic [1:0]                   space,
    input  logic                         addr_msb,
    output logic [WAIT_W-1:0]            wait_cnt
);
    import ws_pkg::*;

    logic [WAIT_W-1:0] fld [NUM_FIELDS];

    // Unpack the flat register into one entry per field
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_unpack
        assign fld[k] = fields[k*WAIT_W +: WAIT_W];
    end

    // Space multiplexer
    always_comb begin
        case (space)
            SP_DATA: wait_cnt = fld[FLD_DATA];
            SP_PROG: wait_cnt = addr_msb ? fld[FLD_PHI] : fld[FLD_PLO];
            default: wait_cnt = fld[FLD_IO];
        endcase
    end
endmodule

// File: rtl/ws_counter.sv
// Module: per-access wait counter with READY stretching.
// Latches the count on a start while idle, counts it down, then waits for
// ext_ready. Starts that arrive while busy are ignored.
module ws_counter #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_in,
    input  logic              ext_ready,
    output logic              bus_ready
);
    logic              busy;
    logic [WAIT_W-1:0] remain;
    logic              expired;

    // Completion condition for the start cycle or a running access
    always_comb begin
        expired   = busy ? (remain == '0) : (wait_in == '0);
        bus_ready = (busy || start) && expired && ext_ready;
    end

    // Access state: load on start, count down, release on READY
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (start && !((wait_in == '0) && ext_ready)) begin
                busy   <= 1'b1;
                remain <= (wait_in == '0) ? '0 : wait_in - 1'b1;
            end
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else if (ext_ready) begin
            busy <= 1'b0;
        end
    end

    assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain != '0) |=> (busy && remain == $past(remain) - 1'b1));

    assert_ready_needs_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> ext_ready);

    assert_stretch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain == '0 && !ext_ready) |=> busy);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/waitgen_top.sv
// Module: top of the per-space wait-state inserter.
// Joins the configuration register, the space selector and the counter.
// Assumes the core holds acc_space and acc_addr_msb valid in the start cycle.
module waitgen_top #(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] CFG_ADDR = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic [1:0]        acc_space,
    input  logic              acc_addr_msb,
    input  logic              ext_ready,
    output logic              bus_ready,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    import ws_pkg::*;

    localparam int CFG_W = NUM_FIELDS * WAIT_W;

    logic [CFG_W-1:0]  fields;
    logic [WAIT_W-1:0] wait_cnt;

    ws_cfg_reg #(
        .WAIT_W(WAIT_W), .NUM_FIELDS(NUM_FIELDS),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .fields(fields)
    );

    ws_field_sel #(.WAIT_W(WAIT_W), .NUM_FIELDS(NUM_FIELDS)) u_sel (
        .fields(fields), .space(acc_space), .addr_msb(acc_addr_msb),
        .wait_cnt(wait_cnt)
    );

    ws_counter #(.WAIT_W(WAIT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(acc_start), .wait_in(wait_cnt),
        .ext_ready(ext_ready), .bus_ready(bus_ready)
    );

    assert_zero_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && ext_ready && wait_cnt == '0 && !$past(acc_start && !bus_ready))
        |-> bus_ready);
endmodule

// File: tb/waitgen_top_tb.sv
module waitgen_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0;
    logic [1:0]  acc_space = 2'd0;
    logic        acc_addr_msb = 1'b0;
    logic        ext_ready = 1'b1;
    logic        bus_ready;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    waitgen_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_space(acc_space),
        .acc_addr_msb(acc_addr_msb), .ext_ready(ext_ready), .bus_ready(bus_ready),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    localparam logic [15:0] CFG = 16'hFFFC;
    localparam int NV = 12;
    // Vector columns: register value, space, address MSB, READY-low cycles, expected latency
    localparam int V_CFG [NV] = '{'h688, 'h688, 'h688, 'h688, 'h177, 'h177,
                                  'h177, 'h177, 'h688, 'h688, 'h688, 'hFFF};
    localparam int V_SP  [NV] = '{1, 1, 0, 2, 1, 1, 0, 2, 2, 2, 1, 0};
    localparam int V_MSB [NV] = '{0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
    localparam int V_LOW [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 2, 5, 3, 9};
    localparam int V_EXP [NV] = '{0, 1, 2, 3, 7, 6, 5, 0, 3, 5, 3, 9};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic write_reg(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [15:0] a, output int v);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 v = int'(reg_rdata);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    // One access; returns the cycle index (0 = start cycle) of bus_ready.
    // wr_at / pulse_at inject a register write / an extra start at that cycle index.
    task automatic run_access(input int sp, input int msb, input int low,
                              input int wr_at, input int wr_val,
                              input int pulse_at, output int lat);
        @(negedge clk);
        acc_start = 1'b1; acc_space = 2'(sp); acc_addr_msb = msb[0];
        ext_ready = (low == 0);
        reg_wr_en = (wr_at == 0); reg_addr = CFG; reg_wdata = 16'(wr_val);
        lat = -1;
        for (int c = 0; c < 40; c++) begin
            #1;
            if (bus_ready) begin
                lat = c;
                break;
            end
            @(negedge clk);
            acc_start = (c + 1 == pulse_at);
            ext_ready = (c + 1 >= low);
            reg_wr_en = (c + 1 == wr_at);
        end
        @(negedge clk);
        acc_start = 1'b0; ext_ready = 1'b1; reg_wr_en = 1'b0;
    endtask

    initial begin
        int v;
        int lat;
        int quiet;
        repeat (3) @(negedge clk);
        #1 check("R4 idle bus_ready", int'(bus_ready), 0);
        rst_n = 1'b1;
        read_reg(CFG, v);
        check("R4 reset value", v, 'h0FFF);
        run_access(1, 1, 0, -1, 0, -1, lat);
        check("R4 reset latency", lat, 7);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            write_reg(CFG, 16'(V_CFG[i]));
            run_access(V_SP[i], V_MSB[i], V_LOW[i], -1, 0, -1, lat);
            if (V_EXP[i] == 0 && V_LOW[i] == 0)
                check($sformatf("R1 vec %0d", i), lat, V_EXP[i]);
            else if (V_LOW[i] == 0)
                check($sformatf("R2 vec %0d", i), lat, V_EXP[i]);
            else if (V_LOW[i] <= V_EXP[i])
                check($sformatf("R5 vec %0d", i), lat, V_EXP[i]);
            else
                check($sformatf("R6 vec %0d", i), lat, V_EXP[i]);
        end

        // Reserved bits
        write_reg(CFG, 16'hFFFF);
        read_reg(CFG, v);
        check("R3 reserved read zero", v, 'h0FFF);

        // Address decode
        write_reg(CFG, 16'h0688);
        write_reg(16'hFFFD, 16'h0000);
        read_reg(CFG, v);
        check("R7 stray write ignored", v, 'h0688);
        read_reg(16'hFFFD, v);
        check("R7 other address reads zero", v, 0);
        run_access(2, 0, 0, -1, 0, -1, lat);
        check("R7 stray write no latency effect", lat, 3);

        // Write in the start cycle: data count 2 still used
        run_access(0, 0, 0, 0, 'h000, -1, lat);
        check("R8 write at start", lat, 2);
        run_access(0, 0, 0, -1, 0, -1, lat);
        check("R8 next access uses new value", lat, 0);

        // Write mid-access
        write_reg(CFG, 16'h0688);
        run_access(2, 0, 0, 1, 'h000, -1, lat);
        check("R8 write mid access", lat, 3);
        run_access(2, 0, 0, -1, 0, -1, lat);
        check("R8 later access", lat, 0);

        // Extra start mid-access
        write_reg(CFG, 16'h0E00);
        run_access(2, 0, 0, -1, 0, 3, lat);
        check("R9 restart ignored latency", lat, 7);
        quiet = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            #1 if (bus_ready) quiet++;
        end
        check("R9 no second access", quiet, 0);

        finish_run();
    end
endmodule